// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block sequences a byte-level I2C master engine through one register-style transfer at a time. A request names a 7-bit target, a direction, a register subaddress of zero to `SUB_BYTES` bytes and a data length. The sequencer then issues the address byte, the subaddress bytes, the write data or the read dummies, the stop commands and, when needed, a repeated start. It does this in response to the engine's transmit-empty, receive-full and NAK flags, which it treats as levels.

On a write, data bytes come from a valid/ready input stream. On a read, every byte the engine receives during the data phase appears for one cycle on an output stream. Bytes that the engine echoes back while it is transmitting are popped and dropped. Status outputs give busy, a one-cycle done pulse, a sticky NAK error and the number of data bytes moved so far.

All engine commands are combinational from the current state and the flags, so the engine sees them in the same cycle as the flag that called for them. A stop command is a frame-length write of zero together with a transmit byte of 0x00.

Top module: `i2c_regseq`

## Requirements
- R1: An accepted request (`req_valid` while idle) writes the address byte `{addr, rw}` and a frame length of 1 + subaddress length + data length in the same cycle. A read that has a nonzero subaddress length instead uses rw=0 and leaves the data length out of the frame length.
- R2: Subaddress bytes are sent one per transmit-empty cycle, most significant byte first. The byte sent is `req_sub >> (8 * bytes_still_unsent_after_it)`.
- R3: After the last subaddress byte of a read, the next transmit-empty cycle writes a filler of 0xFF. The transmit-empty cycle after that writes frame length = data length + 1 together with the address byte with rw=1.
- R4: In the read data phase, a transmit-empty cycle writes a dummy of 0xFF only while more than one byte remains to be received. In the receive-begin phase, a transmit-empty cycle with no receive-full also writes a dummy of 0xFF.
- R5: When exactly one read byte remains, `eng_ack_en` drops to 0 on the next edge, and a stop (frame length 0 plus byte 0x00) is issued in that same cycle.
- R6: A receive-full in any state other than read data is popped (`eng_rx_rd`) and dropped. In read data, a receive-full is popped and shown on `rd_valid`/`rd_data`, and the final byte ends the transfer.
- R7: Write data is taken only when `wr_ready` and `wr_valid` are both high, one byte per transmit-empty cycle. Without `wr_valid` nothing is written. Once the data is exhausted, a transmit-empty issues a stop. The transfer then ends on the next receive-full, and transmit-empty is ignored until then.
- R8: A NAK pops the receive byte, pulses `eng_abort`, sets `nak_err` and returns to idle. The exceptions are a NAK once write data is exhausted and a NAK while exactly one read byte remains: these only pulse `eng_nak_clr`.
- R9: A request made while busy pulses `req_rej`. The request starts nothing and the running transfer continues.
- R10: `busy` is high from the edge after acceptance until the edge at which the transfer ends. At that edge `done` is high for exactly one cycle. `xfer_count` equals the requested length minus the data bytes still remaining.
- R11: After reset the block is idle, with `done`=0, `nak_err`=0, `eng_ack_en`=1 and no engine command asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_sub | input | 8*SUB_BYTES | Register subaddress |
| req_sub_len | input | SUBL_W | Subaddress length in bytes |
| req_len | input | LEN_W | Data length in bytes |
| req_rej | output | 1 | Request refused because busy |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| nak_err | output | 1 | Last transfer ended by an unexpected NAK |
| xfer_count | output | LEN_W | Data bytes transferred |
| wr_valid | input | 1 | Write data available |
| wr_data | input | 8 | Write data byte |
| wr_ready | output | 1 | Sequencer can take a write byte this cycle |
| rd_valid | output | 1 | Received data byte valid |
| rd_data | output | 8 | Received data byte |
| eng_tx_empty | input | 1 | Engine can accept a byte |
| eng_rx_full | input | 1 | Engine holds a received byte |
| eng_nak | input | 1 | Engine saw a NAK |
| eng_rx_data | input | 8 | Engine received byte |
| eng_tx_wr | output | 1 | Write byte to engine |
| eng_tx_data | output | 8 | Byte to engine |
| eng_rx_rd | output | 1 | Pop engine received byte |
| eng_nak_clr | output | 1 | Clear engine NAK flag |
| eng_frm_wr | output | 1 | Load frame length |
| eng_frm_val | output | FRM_W | Frame length in bytes |
| eng_ack_en | output | 1 | Acknowledge received bytes |
| eng_abort | output | 1 | Abort-stop command |

## Verification
The echo drop and a transmit action can fall in the same cycle: a receive-full that drops an echo while a transmit-empty sends a subaddress byte, a filler or the first write byte. A NAK exception can also coincide with the final read byte being delivered or with the write-side stop. The bench provokes these by raising transmit-empty, receive-full and NAK together in one vector. It then judges every engine command line in that cycle against the expected pop, write and frame-length values.

// File: rtl/irs_pkg.sv
package irs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CHK  = 3'd1,
    ST_SUB  = 3'd2,
    ST_SEND = 3'd3,
    ST_RBEG = 3'd4,
    ST_RDAT = 3'd5
  } irs_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] STOP_BYTE = 8'h00;

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction
endpackage

// File: rtl/irs_sub_sel.sv
module irs_sub_sel #(
  parameter int SUB_BYTES = 4,
  localparam int SUBL_W = $clog2(SUB_BYTES + 1)
) (
  input  logic [8*SUB_BYTES-1:0] sub,
  input  logic [SUBL_W-1:0]      idx,
  output logic [7:0]             byte_o
);
  logic [7:0] lanes [SUB_BYTES];

  for (genvar g = 0; g < SUB_BYTES; g++) begin : g_lane
    assign lanes[g] = sub[8*g +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < SUB_BYTES; i++)
      if (idx == SUBL_W'(i)) byte_o = lanes[i];
  end
endmodule

// File: rtl/irs_remain_ctr.sv
module irs_remain_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic [LEN_W-1:0] rem,
  output logic [LEN_W-1:0] moved
);
  logic [LEN_W-1:0] total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      total <= '0;
    end else if (load) begin
      rem   <= load_val;
      total <= load_val;
    end else if (dec && rem != '0) begin
      rem <= rem - 1'b1;
    end
  end

  assign moved = total - rem;
endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
  import irs_pkg::*;
#(
  parameter int SUB_BYTES = 4,
  parameter int LEN_W     = 8,
  localparam int SUBL_W   = $clog2(SUB_BYTES + 1),
  localparam int FRM_W    = LEN_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [6:0]             req_addr,
  input  logic                   req_read,
  input  logic [8*SUB_BYTES-1:0] req_sub,
  input  logic [SUBL_W-1:0]      req_sub_len,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   req_rej,
  output logic                   busy,
  output logic                   done,
  output logic                   nak_err,
  output logic [LEN_W-1:0]       xfer_count,
  input  logic                   wr_valid,
  input  logic [7:0]             wr_data,
  output logic                   wr_ready,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  input  logic                   eng_tx_empty,
  input  logic                   eng_rx_full,
  input  logic                   eng_nak,
  input  logic [7:0]             eng_rx_data,
  output logic                   eng_tx_wr,
  output logic [7:0]             eng_tx_data,
  output logic                   eng_rx_rd,
  output logic                   eng_nak_clr,
  output logic                   eng_frm_wr,
  output logic [FRM_W-1:0]       eng_frm_val,
  output logic                   eng_ack_en,
  output logic                   eng_abort
);
  function automatic logic [FRM_W-1:0] frame_first(input logic [SUBL_W-1:0] sl,
                                                    input logic [LEN_W-1:0] ln,
                                                    input logic restart);
    return FRM_W'(1) + FRM_W'(sl) + (restart ? '0 : FRM_W'(ln));
  endfunction

  irs_state_e        st, st_n, eff_st;
  logic [SUBL_W-1:0] sub_rem, sub_rem_n, sub_idx;
  logic              fill_q, fill_n, stop_q, stop_n, ack_q, ack_n, err_q, err_n, done_q, done_n;
  logic [6:0]        addr_q;
  logic              rd_q;
  logic [8*SUB_BYTES-1:0] sub_q;
  logic [LEN_W-1:0]  rem;
  logic [7:0]        sub_byte;

  // named internal events
  logic accept, need_rs, nak_ok, ev_nak_abort, ev_echo, ev_stop, rem_dec, flag_ev;

  assign need_rs = (req_sub_len != '0) && req_read;
  assign sub_idx = sub_rem - 1'b1;
  assign eff_st  = (st == ST_CHK) ? (rd_q ? ST_RBEG : ST_SEND) : st;
  assign nak_ok  = (st == ST_SEND && rem == '0) ||
                   ((st == ST_RBEG || st == ST_RDAT) && rem == LEN_W'(1));
  assign flag_ev = eng_tx_empty || eng_rx_full;

  irs_sub_sel #(.SUB_BYTES(SUB_BYTES)) u_sub_sel (
    .sub(sub_q), .idx(sub_idx), .byte_o(sub_byte)
  );

  irs_remain_ctr #(.LEN_W(LEN_W)) u_rem (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(req_len),
    .dec(rem_dec), .rem(rem), .moved(xfer_count)
  );

  always_comb begin
    st_n = st; sub_rem_n = sub_rem; fill_n = fill_q; stop_n = stop_q;
    ack_n = ack_q; err_n = err_q; done_n = 1'b0;
    eng_tx_wr = 1'b0; eng_tx_data = '0; eng_rx_rd = 1'b0; eng_nak_clr = 1'b0;
    eng_frm_wr = 1'b0; eng_frm_val = '0; eng_abort = 1'b0;
    wr_ready = 1'b0; rd_valid = 1'b0; req_rej = 1'b0;
    accept = 1'b0; rem_dec = 1'b0; ev_stop = 1'b0; ev_nak_abort = 1'b0; ev_echo = 1'b0;
    if (st == ST_IDLE) begin
      if (req_valid) begin
        accept      = 1'b1;
        eng_tx_wr   = 1'b1;
        eng_tx_data = addr_byte(req_addr, req_read && !need_rs);
        eng_frm_wr  = 1'b1;
        eng_frm_val = frame_first(req_sub_len, req_len, need_rs);
        st_n        = (req_sub_len != '0) ? ST_SUB : ST_CHK;
        sub_rem_n   = req_sub_len;
        fill_n = 1'b0; stop_n = 1'b0; err_n = 1'b0; ack_n = 1'b1;
      end
    end else begin
      req_rej     = req_valid;
      eng_nak_clr = eng_nak;
      if (eng_nak && !nak_ok) begin
        ev_nak_abort = 1'b1;
        eng_rx_rd    = eng_rx_full;
        eng_abort    = 1'b1;
        st_n = ST_IDLE; err_n = 1'b1; done_n = 1'b1;
      end else if (flag_ev) begin
        st_n = eff_st;
        if (eng_rx_full && eff_st != ST_RDAT) begin
          eng_rx_rd = 1'b1;
          ev_echo   = 1'b1;
        end
        unique case (eff_st)
          ST_SUB: if (eng_tx_empty) begin
            if (sub_rem != '0) begin
              eng_tx_wr = 1'b1; eng_tx_data = sub_byte; sub_rem_n = sub_rem - 1'b1;
            end else if (!rd_q) begin
              if (rem == '0) st_n = ST_SEND;
              else begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                  eng_tx_wr = 1'b1; eng_tx_data = wr_data; rem_dec = 1'b1; st_n = ST_SEND;
                end
              end
            end else if (!fill_q) begin
              eng_tx_wr = 1'b1; eng_tx_data = FILL_BYTE; fill_n = 1'b1;
            end else begin
              eng_frm_wr  = 1'b1;
              eng_frm_val = FRM_W'(rem) + FRM_W'(1);
              eng_tx_wr   = 1'b1;
              eng_tx_data = addr_byte(addr_q, 1'b1);
              st_n        = ST_RBEG;
            end
          end
          ST_SEND: begin
            if (stop_q) begin
              if (eng_rx_full) begin st_n = ST_IDLE; done_n = 1'b1; end
            end else if (eng_tx_empty) begin
              if (rem != '0) begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                  eng_tx_wr = 1'b1; eng_tx_data = wr_data; rem_dec = 1'b1;
                end
              end else begin
                ev_stop = 1'b1; stop_n = 1'b1;
              end
            end
          end
          ST_RBEG: begin
            if (eng_rx_full) begin
              st_n = ST_RDAT;
              if (rem == LEN_W'(1)) begin ack_n = 1'b0; ev_stop = 1'b1; end
              else ack_n = 1'b1;
            end else if (eng_tx_empty) begin
              eng_tx_wr = 1'b1; eng_tx_data = FILL_BYTE;
            end
          end
          ST_RDAT: begin
            if (eng_rx_full) begin
              eng_rx_rd = 1'b1; rd_valid = 1'b1; rem_dec = 1'b1;
              if (rem <= LEN_W'(1)) begin st_n = ST_IDLE; done_n = 1'b1; end
              else if (rem == LEN_W'(2)) begin ack_n = 1'b0; ev_stop = 1'b1; end
            end else if (eng_tx_empty && rem > LEN_W'(1)) begin
              eng_tx_wr = 1'b1; eng_tx_data = FILL_BYTE;
            end
          end
          default: ;
        endcase
      end
    end
    if (ev_stop) begin
      eng_frm_wr = 1'b1; eng_frm_val = '0;
      eng_tx_wr  = 1'b1; eng_tx_data = STOP_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sub_rem <= '0; fill_q <= 1'b0; stop_q <= 1'b0;
      ack_q <= 1'b1; err_q <= 1'b0; done_q <= 1'b0;
      addr_q <= '0; rd_q <= 1'b0; sub_q <= '0;
    end else begin
      st <= st_n; sub_rem <= sub_rem_n; fill_q <= fill_n; stop_q <= stop_n;
      ack_q <= ack_n; err_q <= err_n; done_q <= done_n;
      if (accept) begin
        addr_q <= req_addr; rd_q <= req_read; sub_q <= req_sub;
      end
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign nak_err    = err_q;
  assign eng_ack_en = ack_q;
  assign rd_data    = eng_rx_data;
endmodule

// File: rtl/irs_checker.sv
module irs_checker #(
  parameter int FRM_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             nak_err,
  input logic             eng_tx_empty,
  input logic             eng_rx_full,
  input logic             eng_tx_wr,
  input logic             eng_rx_rd,
  input logic             eng_frm_wr,
  input logic [FRM_W-1:0] eng_frm_val,
  input logic             eng_ack_en,
  input logic             eng_abort
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);                                    // R10
  AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                             // R10
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> (!busy && nak_err));                                 // R8
  AST_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_rd |-> eng_rx_full);                                        // R6
  AST_DATA_WR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_wr && busy && !eng_frm_wr) |-> eng_tx_empty);              // R7
  AST_ACK_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_ack_en) |-> $past(eng_frm_wr && eng_frm_val == '0));     // R5
endmodule

bind i2c_regseq irs_checker #(.FRM_W(FRM_W)) u_irs_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .nak_err(nak_err), .eng_tx_empty(eng_tx_empty), .eng_rx_full(eng_rx_full),
  .eng_tx_wr(eng_tx_wr), .eng_rx_rd(eng_rx_rd), .eng_frm_wr(eng_frm_wr),
  .eng_frm_val(eng_frm_val), .eng_ack_en(eng_ack_en), .eng_abort(eng_abort)
);

// File: tb/i2c_regseq_bench.sv
`timescale 1ns/100ps
module i2c_regseq_bench;
  localparam int SUB_BYTES = 4;
  localparam int LEN_W     = 8;
  localparam int SUBL_W    = $clog2(SUB_BYTES + 1);
  localparam int FRM_W     = LEN_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_read = 0, wr_valid = 0;
  logic [6:0] req_addr = '0;
  logic [8*SUB_BYTES-1:0] req_sub = '0;
  logic [SUBL_W-1:0] req_sub_len = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data = '0, eng_rx_data = '0;
  logic eng_tx_empty = 0, eng_rx_full = 0, eng_nak = 0;
  logic req_rej, busy, done, nak_err, wr_ready, rd_valid;
  logic [LEN_W-1:0] xfer_count;
  logic [7:0] rd_data, eng_tx_data;
  logic eng_tx_wr, eng_rx_rd, eng_nak_clr, eng_frm_wr, eng_ack_en, eng_abort;
  logic [FRM_W-1:0] eng_frm_val;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  i2c_regseq #(.SUB_BYTES(SUB_BYTES), .LEN_W(LEN_W)) u_i2c_regseq (
    .clk, .rst_n, .req_valid, .req_addr, .req_read, .req_sub, .req_sub_len, .req_len,
    .req_rej, .busy, .done, .nak_err, .xfer_count, .wr_valid, .wr_data, .wr_ready,
    .rd_valid, .rd_data, .eng_tx_empty, .eng_rx_full, .eng_nak, .eng_rx_data,
    .eng_tx_wr, .eng_tx_data, .eng_rx_rd, .eng_nak_clr, .eng_frm_wr, .eng_frm_val,
    .eng_ack_en, .eng_abort
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [6:0] a, input logic rd, input logic [31:0] s,
                         input int sl, input int ln);
    req_addr = a; req_read = rd; req_sub = s;
    req_sub_len = SUBL_W'(sl); req_len = LEN_W'(ln);
  endtask

  // drive at falling edge, settle, then caller samples before the rising edge
  task automatic step(input logic rq, input logic tx, input logic rx, input logic nk,
                      input logic [7:0] rxd, input logic wv, input logic [7:0] wd);
    @(negedge clk);
    req_valid = rq; eng_tx_empty = tx; eng_rx_full = rx; eng_nak = nk;
    eng_rx_data = rxd; wr_valid = wv; wr_data = wd;
    #1;
  endtask

  // {req,tx,rx,nak,rxd[8], txw,txd[8], rxr,rdv, fw,fv[10], abort,busy, pad[4]}
  // read of 2 bytes from target 0x50, subaddress 0xA1B2 (2 bytes)
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,8'hA0, 1'b0,1'b0, 1'b1,10'd3, 1'b0,1'b0,4'h0},
    {1'b0,1'b1,1'b0,1'b0,8'h00, 1'b1,8'hA1, 1'b0,1'b0, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b1,1'b1,1'b0,8'h00, 1'b1,8'hB2, 1'b1,1'b0, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b1,1'b1,1'b0,8'h00, 1'b1,8'hFF, 1'b1,1'b0, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b1,1'b0,1'b0,8'h00, 1'b1,8'hA1, 1'b0,1'b0, 1'b1,10'd3, 1'b0,1'b1,4'h0},
    {1'b0,1'b0,1'b1,1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b1,1'b0,1'b0,8'h00, 1'b1,8'hFF, 1'b0,1'b0, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b0,1'b1,1'b0,8'h11, 1'b1,8'h00, 1'b1,1'b1, 1'b1,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b0,1'b1,1'b1,8'h22, 1'b0,8'h00, 1'b1,1'b1, 1'b0,10'd0, 1'b0,1'b1,4'h0},
    {1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 1'b0,10'd0, 1'b0,1'b0,4'h0}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 nak_err", nak_err, 0);
    chk("R11 ack_en", eng_ack_en, 1);
    chk("R11 tx_wr", eng_tx_wr, 0);
    rst_n = 1'b1;

    // Table: R1 R2 R3 R4 R5 R6 on a read with a two-byte subaddress
    set_req(7'h50, 1'b1, 32'h0000_A1B2, 2, 2);
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      step(v[39], v[38], v[37], v[36], v[35:28], 1'b0, 8'h00);
      chk($sformatf("R1/R2/R3 vec%0d tx_wr", i), eng_tx_wr, v[27]);
      if (v[27]) chk($sformatf("R2/R3/R4 vec%0d tx_data", i), eng_tx_data, v[26:19]);
      chk($sformatf("R6 vec%0d rx_rd", i), eng_rx_rd, v[18]);
      chk($sformatf("R6 vec%0d rd_valid", i), rd_valid, v[17]);
      if (v[17]) chk($sformatf("R6 vec%0d rd_data", i), rd_data, v[35:28]);
      chk($sformatf("R3/R5 vec%0d frm_wr", i), eng_frm_wr, v[16]);
      if (v[16]) chk($sformatf("R1/R3 vec%0d frm_val", i), eng_frm_val, v[15:6]);
      chk($sformatf("R8 vec%0d abort", i), eng_abort, v[5]);
      chk($sformatf("R10 vec%0d busy", i), busy, v[4]);
      if (i == 6) chk("R5 ack before last", eng_ack_en, 1);
      if (i == 8) chk("R5 ack off last", eng_ack_en, 0);
      if (i == 9) chk("R8 nak_clr on last read", eng_nak_clr, 1);
      if (i == 10) begin
        chk("R10 done", done, 1);
        chk("R10 count", xfer_count, 2);
        chk("R8 no err", nak_err, 0);
      end
    end

    // R7: write of 2 bytes, subaddress 0x07, target 0x2C
    set_req(7'h2C, 1'b0, 32'h0000_0007, 1, 2);
    step(1, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R1 wr addr", eng_tx_data, 8'h58);
    chk("R1 wr frame", eng_frm_val, 4);
    step(0, 1, 0, 0, 8'h00, 0, 8'h00);
    chk("R2 wr sub", eng_tx_data, 8'h07);
    step(0, 1, 1, 0, 8'h00, 0, 8'h00);
    chk("R6 echo pop", eng_rx_rd, 1);
    chk("R7 ready", wr_ready, 1);
    chk("R7 stall no write", eng_tx_wr, 0);
    step(0, 1, 0, 0, 8'h00, 1, 8'h5A);
    chk("R7 byte0", eng_tx_data, 8'h5A);
    chk("R7 byte0 wr", eng_tx_wr, 1);
    step(0, 1, 0, 0, 8'h00, 1, 8'h6B);
    chk("R7 byte1", eng_tx_data, 8'h6B);
    chk("R10 count mid", xfer_count, 1);
    step(0, 1, 1, 1, 8'h00, 0, 8'h00);
    chk("R8 final write nak no abort", eng_abort, 0);
    chk("R8 nak_clr", eng_nak_clr, 1);
    chk("R7 stop frame", eng_frm_wr, 1);
    chk("R7 stop byte", eng_tx_data, 8'h00);
    chk("R6 echo pop with stop", eng_rx_rd, 1);
    step(1, 1, 0, 0, 8'h00, 0, 8'h00);
    chk("R9 reject", req_rej, 1);
    chk("R9 no start", eng_tx_wr, 0);
    chk("R7 tx ignored after stop", eng_frm_wr, 0);
    step(0, 0, 1, 0, 8'h00, 0, 8'h00);
    chk("R9 still busy", busy, 1);
    chk("R7 final pop", eng_rx_rd, 1);
    step(0, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R7 idle", busy, 0);
    chk("R10 done wr", done, 1);
    chk("R10 count wr", xfer_count, 2);
    chk("R8 no err wr", nak_err, 0);

    // R8: address NAK aborts
    set_req(7'h10, 1'b0, 32'h0, 0, 3);
    step(1, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R1 nosub frame", eng_frm_val, 4);
    chk("R1 nosub addr", eng_tx_data, 8'h20);
    step(0, 1, 1, 1, 8'h00, 0, 8'h00);
    chk("R8 abort", eng_abort, 1);
    chk("R8 pop", eng_rx_rd, 1);
    chk("R8 no write", eng_tx_wr, 0);
    step(0, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R8 idle", busy, 0);
    chk("R8 err", nak_err, 1);
    chk("R10 count abort", xfer_count, 0);
    step(0, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R10 done one cycle", done, 0);

    // R1/R5: one-byte read without subaddress
    set_req(7'h33, 1'b1, 32'h0, 0, 1);
    step(1, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R1 direct read addr", eng_tx_data, 8'h67);
    chk("R1 direct read frame", eng_frm_val, 2);
    step(0, 1, 1, 0, 8'h00, 0, 8'h00);
    chk("R6 begin pop", eng_rx_rd, 1);
    chk("R5 stop frame", eng_frm_wr, 1);
    chk("R5 stop byte", eng_tx_data, 8'h00);
    step(0, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R5 ack off", eng_ack_en, 0);
    chk("R8 err cleared", nak_err, 0);
    step(0, 0, 1, 1, 8'h9C, 0, 8'h00);
    chk("R6 deliver", rd_valid, 1);
    chk("R6 data", rd_data, 8'h9C);
    chk("R8 last read nak no abort", eng_abort, 0);
    step(0, 0, 0, 0, 8'h00, 0, 8'h00);
    chk("R10 read done", done, 1);
    chk("R10 read count", xfer_count, 1);
    chk("R10 idle", busy, 0);

    finish_run();
  end
endmodule